// File: doc/BRIEF.md
# Trace-Logging Memory Emulator

This block takes the place of the static RAM on a processor's external memory bus. Reads and writes are served from an on-chip word array. A second, independent on-chip array records a trace entry for each access. Each entry holds the value of a free-running cycle counter, the direction of the access, the word address and the data word. The trace array is a ring: once it is full, each new entry replaces the oldest one. As a result, the most recent `TRACE_DEPTH` accesses are always kept.

A run is opened with a one-cycle `run_start` pulse. This pulse clears the ring and the counter and turns logging on. A `run_stop` pulse turns logging off. The memory keeps serving accesses after that, but they are no longer recorded. After the run, `dump_start` streams the retained entries out over a valid/ready handshake, oldest first. `dump_count` tells the receiver how many entries to expect, and a `dump_done` pulse closes the stream. Logging costs the processor port nothing: every access completes in the cycle it is presented, whatever the trace side is doing.

Top module: `memtrace_emu`

## Requirements
- R1: A write with `mem_en`=1 and `mem_we`=1 stores `mem_wdata` at `mem_addr`. A read (`mem_en`=1, `mem_we`=0) accepted at a clock edge puts the stored word on `mem_rdata`, with `mem_rvalid` high for exactly the following cycle only.
- R2: Each access accepted while logging is on, read or write, adds exactly one trace entry. `dump_count` reports the number of entries retained and is 0 after reset.
- R3: In an entry, `dump_we` is 1 for a write and 0 for a read, and `dump_addr` is the accessed address. `dump_data` is the value written, or for a read the value the memory returned.
- R4: `dump_ts` is the timestamp counter's value in the cycle the access was accepted. The counter reads 0 in the cycle after a `run_start` edge, adds one every cycle, and wraps modulo 2^`TS_W` without any indication.
- R5: At most `TRACE_DEPTH` entries are retained. Each further entry overwrites the oldest one, and `dump_count` stays at `TRACE_DEPTH`.
- R6: The readout delivers the retained entries in order, from the oldest to the newest. The first entry is the oldest one still kept, and it is also the first of the run when the ring never filled.
- R7: After `run_stop`, accesses are still served but are not recorded. A `dump_start` given while logging is on is ignored.
- R8: An entry shown with `dump_valid`=1 keeps all its fields stable until `dump_ready` is seen high.
- R9: `dump_done` is a single-cycle pulse in the cycle after the final entry's handshake. When no entries are retained, it comes in the cycle after `dump_start` and no entry is shown.
- R10: `run_start` discards the previous trace. A later readout shows only the accesses logged since then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_start | input | 1 | Pulse: clear trace and timestamp, enable logging |
| run_stop | input | 1 | Pulse: disable logging |
| mem_en | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | ADDR_W | Word address |
| mem_wdata | input | DATA_W | Write data |
| mem_rdata | output | DATA_W | Read data |
| mem_rvalid | output | 1 | Read data valid (cycle after read) |
| dump_start | input | 1 | Pulse: begin trace readout (logging off) |
| dump_ready | input | 1 | Receiver accepts the shown entry |
| dump_valid | output | 1 | An entry is shown |
| dump_ts | output | TS_W | Entry timestamp |
| dump_we | output | 1 | Entry direction, 1 = write |
| dump_addr | output | ADDR_W | Entry address |
| dump_data | output | DATA_W | Entry data |
| dump_count | output | log2(TRACE_DEPTH)+1 | Number of retained entries |
| dump_done | output | 1 | Pulse after the last entry |

## Verification
Read data and `mem_rvalid` are due one cycle after the edge that accepts the read. The bench drives every access on a falling edge and compares the read result at the next falling edge against a queued model value. The timestamp an entry must carry is the bench's own counter value in the driving cycle, because the design samples it on the accepting edge. In the readout, an entry becomes visible two edges after `dump_start` or after the previous handshake, and `dump_done` one edge after the last handshake. The bench polls for `dump_valid` within a short bound and then checks `dump_done` at exactly the falling edge that follows the final handshake.

// File: rtl/mte_pkg.sv
package mte_pkg;

   typedef enum logic [1:0] {
      RO_IDLE  = 2'd0,
      RO_FETCH = 2'd1,
      RO_SHOW  = 2'd2,
      RO_DONE  = 2'd3
   } ro_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/mte_ram.sv
module mte_ram #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 512,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [W-1:0]  wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  rd_data
);

   logic [W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
      if (rd_en) rd_data <= store[rd_addr];
   end

endmodule

// File: rtl/mte_logger.sv
module mte_logger #(
   parameter int unsigned TS_W  = 32,
   parameter int unsigned AW    = 10,
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 512,
   parameter int unsigned PW    = $clog2(DEPTH),
   parameter int unsigned CW    = PW + 1,
   parameter int unsigned RW    = TS_W + 1 + AW + DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_start,
   input  logic          run_stop,
   input  logic          acc_en,
   input  logic          acc_we,
   input  logic [AW-1:0] acc_addr,
   input  logic [DW-1:0] acc_wdata,
   input  logic [DW-1:0] acc_rdata,
   output logic          log_active,
   output logic          tr_we,
   output logic [PW-1:0] tr_addr,
   output logic [RW-1:0] tr_rec,
   output logic [CW-1:0] rec_count,
   output logic [PW-1:0] oldest_ptr
);

   logic [TS_W-1:0] ts;
   logic            stg_v;
   logic [TS_W-1:0] stg_ts;
   logic            stg_we;
   logic [AW-1:0]   stg_addr;
   logic [DW-1:0]   stg_wdata;
   logic [PW-1:0]   wr_ptr;
   logic            wrapped;

   // accepted access is staged one cycle so read data can join it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_active <= 1'b0;
         ts         <= '0;
         stg_v      <= 1'b0;
         stg_ts     <= '0;
         stg_we     <= 1'b0;
         stg_addr   <= '0;
         stg_wdata  <= '0;
         wr_ptr     <= '0;
         wrapped    <= 1'b0;
      end else begin
         ts <= run_start ? '0 : ts + TS_W'(1);
         if (run_start)     log_active <= 1'b1;
         else if (run_stop) log_active <= 1'b0;
         stg_v <= log_active & acc_en & ~run_start;
         if (log_active && acc_en) begin
            stg_ts    <= ts;
            stg_we    <= acc_we;
            stg_addr  <= acc_addr;
            stg_wdata <= acc_wdata;
         end
         if (run_start) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
         end else if (stg_v) begin
            wr_ptr <= wr_ptr + PW'(1);
            if (wr_ptr == PW'(DEPTH - 1)) wrapped <= 1'b1;
         end
      end
   end

   assign tr_we      = stg_v;
   assign tr_addr    = wr_ptr;
   assign tr_rec     = {stg_ts, stg_we, stg_addr, stg_we ? stg_wdata : acc_rdata};
   assign rec_count  = wrapped ? CW'(DEPTH) : {1'b0, wr_ptr};
   assign oldest_ptr = wrapped ? wr_ptr : '0;

   p_count_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rec_count <= CW'(DEPTH));

   p_wrap_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_count == CW'(DEPTH) && !run_start) |=> rec_count == CW'(DEPTH));

   p_commit_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tr_we && !run_start) |=>
         (rec_count == $past(rec_count) + CW'(1)) || (rec_count == CW'(DEPTH)));

   p_idle_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !log_active |=> !tr_we);

   p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      run_start |=> (rec_count == '0) && (ts == '0));

endmodule

// File: rtl/mte_readout.sv
module mte_readout import mte_pkg::*; #(
   parameter int unsigned RW    = 59,
   parameter int unsigned DEPTH = 512,
   parameter int unsigned PW    = $clog2(DEPTH),
   parameter int unsigned CW    = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_start,
   input  logic          log_active,
   input  logic          dump_start,
   input  logic [CW-1:0] rec_count,
   input  logic [PW-1:0] oldest_ptr,
   output logic          rd_en,
   output logic [PW-1:0] rd_addr,
   input  logic [RW-1:0] rd_rec,
   output logic          dump_valid,
   input  logic          dump_ready,
   output logic [RW-1:0] dump_rec,
   output logic          dump_done
);

   ro_state_e     state;
   logic [PW-1:0] rptr;
   logic [CW-1:0] remaining;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RO_IDLE;
         rptr      <= '0;
         remaining <= '0;
      end else if (run_start) begin
         state <= RO_IDLE;
      end else begin
         unique case (state)
            RO_IDLE: if (dump_start && !log_active) begin
               rptr      <= oldest_ptr;
               remaining <= rec_count;
               state     <= (rec_count == '0) ? RO_DONE : RO_FETCH;
            end
            RO_FETCH: state <= RO_SHOW;
            RO_SHOW: if (dump_ready) begin
               if (remaining == CW'(1)) begin
                  state <= RO_DONE;
               end else begin
                  rptr      <= rptr + PW'(1);
                  remaining <= remaining - CW'(1);
                  state     <= RO_FETCH;
               end
            end
            RO_DONE: state <= RO_IDLE;
            default: state <= RO_IDLE;
         endcase
      end
   end

   assign rd_en      = (state == RO_FETCH);
   assign rd_addr    = rptr;
   assign dump_valid = (state == RO_SHOW);
   assign dump_done  = (state == RO_DONE);
   assign dump_rec   = rd_rec;

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dump_valid && !dump_ready && !run_start) |=> dump_valid && $stable(dump_rec));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dump_done |=> !dump_done);

   p_done_not_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(dump_done && dump_valid));

   p_quiet_while_logging_r7: assert property (@(posedge clk) disable iff (!rst_n)
      log_active |-> !dump_valid);

endmodule

// File: rtl/memtrace_emu.sv
module memtrace_emu import mte_pkg::*; #(
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned TS_W        = 32,
   parameter int unsigned TRACE_DEPTH = 512
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         run_start,
   input  logic                         run_stop,
   input  logic                         mem_en,
   input  logic                         mem_we,
   input  logic [ADDR_W-1:0]            mem_addr,
   input  logic [DATA_W-1:0]            mem_wdata,
   output logic [DATA_W-1:0]            mem_rdata,
   output logic                         mem_rvalid,
   input  logic                         dump_start,
   input  logic                         dump_ready,
   output logic                         dump_valid,
   output logic [TS_W-1:0]              dump_ts,
   output logic                         dump_we,
   output logic [ADDR_W-1:0]            dump_addr,
   output logic [DATA_W-1:0]            dump_data,
   output logic [$clog2(TRACE_DEPTH):0] dump_count,
   output logic                         dump_done
);

   localparam int unsigned MEM_DEPTH = 1 << ADDR_W;
   localparam int unsigned PW        = $clog2(TRACE_DEPTH);
   localparam int unsigned CW        = PW + 1;
   localparam int unsigned RW        = TS_W + 1 + ADDR_W + DATA_W;

   generate
      if (!is_pow2(TRACE_DEPTH) || TRACE_DEPTH < 2) begin : g_bad_depth
         $error("TRACE_DEPTH must be a power of two of at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must lie in 1..12");
      end
      if (TS_W < 2 || DATA_W < 1) begin : g_bad_width
         $error("TS_W must be at least 2 and DATA_W at least 1");
      end
   endgenerate

   logic          log_active;
   logic          tr_we;
   logic [PW-1:0] tr_addr;
   logic [RW-1:0] tr_rec;
   logic [CW-1:0] rec_count;
   logic [PW-1:0] oldest_ptr;
   logic          ro_rd_en;
   logic [PW-1:0] ro_rd_addr;
   logic [RW-1:0] ro_rd_rec;
   logic [RW-1:0] dump_rec;

   mte_ram #(.W(DATA_W), .DEPTH(MEM_DEPTH)) u_emu_ram (
      .clk     (clk),
      .wr_en   (mem_en & mem_we),
      .wr_addr (mem_addr),
      .wr_data (mem_wdata),
      .rd_en   (mem_en & ~mem_we),
      .rd_addr (mem_addr),
      .rd_data (mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_rvalid <= 1'b0;
      else        mem_rvalid <= mem_en & ~mem_we;
   end

   mte_logger #(.TS_W(TS_W), .AW(ADDR_W), .DW(DATA_W), .DEPTH(TRACE_DEPTH)) u_log (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_start  (run_start),
      .run_stop   (run_stop),
      .acc_en     (mem_en),
      .acc_we     (mem_we),
      .acc_addr   (mem_addr),
      .acc_wdata  (mem_wdata),
      .acc_rdata  (mem_rdata),
      .log_active (log_active),
      .tr_we      (tr_we),
      .tr_addr    (tr_addr),
      .tr_rec     (tr_rec),
      .rec_count  (rec_count),
      .oldest_ptr (oldest_ptr)
   );

   mte_ram #(.W(RW), .DEPTH(TRACE_DEPTH)) u_trace_ram (
      .clk     (clk),
      .wr_en   (tr_we),
      .wr_addr (tr_addr),
      .wr_data (tr_rec),
      .rd_en   (ro_rd_en),
      .rd_addr (ro_rd_addr),
      .rd_data (ro_rd_rec)
   );

   mte_readout #(.RW(RW), .DEPTH(TRACE_DEPTH)) u_ro (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_start  (run_start),
      .log_active (log_active),
      .dump_start (dump_start),
      .rec_count  (rec_count),
      .oldest_ptr (oldest_ptr),
      .rd_en      (ro_rd_en),
      .rd_addr    (ro_rd_addr),
      .rd_rec     (ro_rd_rec),
      .dump_valid (dump_valid),
      .dump_ready (dump_ready),
      .dump_rec   (dump_rec),
      .dump_done  (dump_done)
   );

   assign {dump_ts, dump_we, dump_addr, dump_data} = dump_rec;
   assign dump_count = rec_count;

   p_rvalid_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we) |=> mem_rvalid);

   p_rvalid_only_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_en && !mem_we) |=> !mem_rvalid);

endmodule

// File: tb/memtrace_emu_test.sv
`timescale 1ns/1ps
module memtrace_emu_test;

   localparam int AW = 10;
   localparam int DW = 16;
   localparam int TW = 8;
   localparam int TD = 512;

   typedef struct {
      logic [TW-1:0] ts;
      logic          we;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
   } rec_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_start = 1'b0, run_stop = 1'b0;
   logic          mem_en = 1'b0, mem_we = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic [DW-1:0] mem_wdata = '0;
   logic [DW-1:0] mem_rdata;
   logic          mem_rvalid;
   logic          dump_start = 1'b0, dump_ready = 1'b0;
   logic          dump_valid, dump_we, dump_done;
   logic [TW-1:0] dump_ts;
   logic [AW-1:0] dump_addr;
   logic [DW-1:0] dump_data;
   logic [9:0]    dump_count;

   memtrace_emu #(.ADDR_W(AW), .DATA_W(DW), .TS_W(TW), .TRACE_DEPTH(TD)) uut (
      .clk, .rst_n, .run_start, .run_stop, .mem_en, .mem_we, .mem_addr, .mem_wdata,
      .mem_rdata, .mem_rvalid, .dump_start, .dump_ready, .dump_valid, .dump_ts,
      .dump_we, .dump_addr, .dump_data, .dump_count, .dump_done);

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit ended = 0;
   logic [DW-1:0] mem_m [1 << AW];
   logic [TW-1:0] ts_m;
   bit            log_m = 0;
   rec_t          exp_q [$];
   logic [DW-1:0] rd_q [$];

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // timestamp model per R4
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ts_m <= '0;
      else if (run_start) ts_m <= '0;
      else                ts_m <= ts_m + 1'b1;
   end

   // read-data monitor (R1): result due at the falling edge after acceptance
   always @(negedge clk) begin
      if (rst_n && mem_rvalid) begin
         if (rd_q.size() == 0) chk(0, "R1 rvalid without read", 1, 0);
         else begin
            logic [DW-1:0] e;
            e = rd_q.pop_front();
            chk(mem_rdata === e, "R1 read data", 64'(mem_rdata), 64'(e));
         end
      end
   end

   task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      rec_t r;
      mem_en = 1'b1; mem_we = we; mem_addr = a; mem_wdata = d;
      r.ts = ts_m; r.we = we; r.addr = a;
      r.data = we ? d : mem_m[a];
      if (we) mem_m[a] = d;
      else    rd_q.push_back(mem_m[a]);
      if (log_m) begin
         exp_q.push_back(r);
         if (exp_q.size() > TD) void'(exp_q.pop_front());
      end
      @(negedge clk);
      mem_en = 1'b0; mem_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_run();
      run_start = 1'b1; log_m = 1; exp_q.delete();
      @(negedge clk);
      run_start = 1'b0;
   endtask

   task automatic stop_run();
      run_stop = 1'b1; log_m = 0;
      @(negedge clk);
      run_stop = 1'b0;
   endtask

   task automatic dump_check(input bit stall);
      int n;
      n = exp_q.size();
      chk(dump_count == 10'(n), "R2 R5 dump_count", 64'(dump_count), 64'(n));
      dump_start = 1'b1;
      @(negedge clk);
      dump_start = 1'b0;
      if (n == 0) begin
         chk(dump_done === 1'b1, "R9 done on empty trace", 64'(dump_done), 1);
         chk(dump_valid === 1'b0, "R9 no entry on empty trace", 64'(dump_valid), 0);
         @(negedge clk);
         return;
      end
      for (int i = 0; i < n; i++) begin
         rec_t e;
         int   w;
         w = 0;
         while (!dump_valid && w < 8) begin
            chk(dump_done === 1'b0, "R9 early done", 64'(dump_done), 0);
            @(negedge clk);
            w++;
         end
         e = exp_q.pop_front();
         chk(dump_valid === 1'b1, "R6 entry shown", 64'(dump_valid), 1);
         chk(dump_ts === e.ts, "R4 R6 timestamp", 64'(dump_ts), 64'(e.ts));
         chk(dump_we === e.we, "R3 direction", 64'(dump_we), 64'(e.we));
         chk(dump_addr === e.addr, "R3 R6 address", 64'(dump_addr), 64'(e.addr));
         chk(dump_data === e.data, "R3 data", 64'(dump_data), 64'(e.data));
         if (stall) begin
            @(negedge clk);
            chk(dump_valid === 1'b1 && dump_addr === e.addr && dump_data === e.data
                && dump_ts === e.ts, "R8 hold while not ready",
                64'({dump_valid, dump_addr}), 64'({1'b1, e.addr}));
         end
         dump_ready = 1'b1;
         @(negedge clk);
         dump_ready = 1'b0;
      end
      chk(dump_done === 1'b1, "R9 done after last", 64'(dump_done), 1);
      @(negedge clk);
      chk(dump_done === 1'b0, "R9 done single cycle", 64'(dump_done), 0);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog (R1 to R10 incomplete): actual timeout expected finish");
      report();
   end

   initial begin
      idle(3);
      chk(dump_count == 0, "R2 reset count", 64'(dump_count), 0);
      chk(mem_rvalid === 1'b0, "R1 reset rvalid", 64'(mem_rvalid), 0);
      chk(dump_valid === 1'b0 && dump_done === 1'b0, "R9 reset idle",
          64'({dump_valid, dump_done}), 0);
      rst_n = 1'b1;
      idle(1);

      // run 1: mixed traffic, stalled readout
      start_run();
      access(1, 10'd5, 16'h1111);      // ts 0 (R4)
      access(1, 10'd6, 16'h2222);
      access(0, 10'd5, '0);
      access(1, 10'd5, 16'h3333);
      access(0, 10'd5, '0);
      access(0, 10'd6, '0);
      idle(3);
      access(1, 10'd1023, 16'hffff);
      access(0, 10'd1023, '0);
      // dump_start while logging is ignored (R7)
      dump_start = 1'b1; idle(1); dump_start = 1'b0;
      idle(3);
      chk(dump_valid === 1'b0 && dump_done === 1'b0, "R7 dump_start ignored while logging",
          64'({dump_valid, dump_done}), 0);
      stop_run();
      idle(2);
      dump_check(1);

      // run 2: restart discards old trace (R10), stopped accesses not logged (R7)
      start_run();
      idle(2);
      access(1, 10'd20, 16'hbeef);
      access(0, 10'd20, '0);
      stop_run();
      access(1, 10'd21, 16'h0a0a);
      access(0, 10'd21, '0);
      idle(2);
      chk(dump_count == 10'd2, "R7 R10 only logged accesses counted", 64'(dump_count), 2);
      dump_check(0);

      // run 3: empty trace
      start_run();
      idle(4);
      stop_run();
      dump_check(0);

      // run 4: overfill ring, timestamp wraps (R4, R5, R6)
      start_run();
      for (int i = 0; i < 600; i++) begin
         if (i % 3 == 2) access(0, 10'(((i - 1) * 7) % 1024), '0);
         else            access(1, 10'((i * 7) % 1024), 16'(i * 37) ^ 16'h5a5a);
         if (i % 50 == 49) idle(i % 4 + 1);
      end
      stop_run();
      idle(2);
      chk(dump_count == 10'(TD), "R5 count saturates", 64'(dump_count), TD);
      dump_check(0);

      idle(2);
      chk(rd_q.size() == 0, "R1 all reads answered", 64'(rd_q.size()), 0);
      report();
   end

endmodule